// File: doc/BRIEF.md
# Host Aperture Window Address Translator

This block sits behind a host base address register and turns each inbound access offset into a target and an address on that target. A 2-bit layout mode picks one of three aperture maps. In every map the lowest 4 KB is a movable window onto a 32-bit backplane. The block also holds two writable window base registers.

The small layout covers 8 KB and carves the upper half into a serial-EEPROM region, a bus-core register region and a bus-core agent region. The split layout covers 16 KB, with 4 KB each for the window, the EEPROM, the bus core and the common core. The dual-window layout is the split layout with the EEPROM quarter replaced by a second window that uses the second base register. All outputs are combinational from the access inputs and the registered window bases. A base register write therefore steers every access from the next cycle on.

Top module: `bar_window_xlate`

## Requirements
- R1: After reset both window bases are zero, so a window access returns an address equal to offset[11:0].
- R2: With layout_mode 0, offsets 0x0000-0x0FFF select target code 1 (window A). The address is window base A with bits 11:0 replaced by offset[11:0].
- R3: With layout_mode 0, offsets 0x1000-0x17FF select target code 3 (EEPROM) with address offset-0x1000.
- R4: With layout_mode 0, offsets 0x1800-0x1BFF select target code 4 (bus core) with address offset[9:0]. Offsets 0x1C00-0x1FFF select code 4 with address 0xC00+offset[9:0].
- R5: With layout_mode 0, any offset of 0x2000 or more raises range_err and gives target code 0 and address 0.
- R6: With layout_mode 1, the map is as follows, with the address offset[11:0] for codes 3 to 5:
  - 0x0000-0x0FFF: code 1, translated as in R2.
  - 0x1000-0x1FFF: code 3.
  - 0x2000-0x2FFF: code 4.
  - 0x3000-0x3FFF: code 5 (common core).
- R7: With layout_mode 2, the map is that of R6, except that 0x1000-0x1FFF selects code 2 (window B), using base B in the same way. Code 3 never appears in this layout.
- R8: layout_mode 3 is invalid. Any valid access in it raises range_err with target code 0 and address 0.
- R9: A write (wr_en, wr_idx 0 = base A, 1 = base B) changes the translation only for accesses in later cycles. An access in the write cycle still uses the old base.
- R10: A write to one base register leaves the other unchanged.
- R11: With acc_valid low, tgt_sel is 0, range_err is 0 and xlat_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offset is valid this cycle |
| acc_offset | input | 14 | Offset inside the aperture |
| layout_mode | input | 2 | Aperture map: 0 small, 1 split, 2 dual window, 3 invalid |
| wr_en | input | 1 | Window base register write strobe |
| wr_idx | input | 1 | Base register written: 0 = A, 1 = B |
| wr_data | input | 32 | New backplane base (bits 11:0 ignored) |
| tgt_sel | output | 3 | 0 none, 1 window A, 2 window B, 3 EEPROM, 4 bus core, 5 common core |
| xlat_addr | output | 32 | Translated address on the selected target |
| range_err | output | 1 | Offset outside the chosen layout, or invalid layout |

## Verification
A corrupted window base is invisible until an access lands in that window. It then shows as wrong upper bits of xlat_addr in that same cycle. A write that lands in the wrong register, or lands one cycle early, is caught on the first window access after it. That is why the bench mixes writes with window accesses in adjacent cycles and on both registers. Decode faults have no state behind them, so they show at once on tgt_sel and range_err. The bench sweeps every region boundary in each layout for that reason.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

   typedef enum logic [2:0] {
      TGT_NONE    = 3'd0,
      TGT_WIN_A   = 3'd1,
      TGT_WIN_B   = 3'd2,
      TGT_EEPROM  = 3'd3,
      TGT_BUSCORE = 3'd4,
      TGT_COMMON  = 3'd5
   } tgt_e;

   typedef enum logic [1:0] {
      LAY_SMALL   = 2'd0,
      LAY_SPLIT   = 2'd1,
      LAY_DUALWIN = 2'd2,
      LAY_BAD     = 2'd3
   } layout_e;

   typedef struct packed {
      tgt_e tgt;
      logic err;
      logic narrow;  // quarter-size core slice of the small layout
      logic agent;   // upper core slice, rebased to the agent block
   } dec_t;

endpackage

// File: rtl/bwx_win_regs.sv
module bwx_win_regs #(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 12,
   localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int BASE_W  = ADDR_W - WIN_BITS
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [ADDR_W-1:0]               wr_data,
   output logic [NUM_WIN-1:0][BASE_W-1:0]  bases
);

   // Only the bits above the window size are stored.
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(w));
      always_ff @(posedge clk) begin
         if (!rst_n)
            bases[w] <= '0;
         else if (hit)
            bases[w] <= wr_data[ADDR_W-1:WIN_BITS];
      end
   end

endmodule

// File: rtl/bwx_region_decode.sv
module bwx_region_decode
   import bwx_pkg::*;
#(
   parameter int OFF_W    = 14,
   parameter int WIN_BITS = 12
) (
   input  logic             acc_valid,
   input  logic [1:0]       layout_mode,
   input  logic [OFF_W-1:0] acc_offset,
   output dec_t             dec
);

   localparam int Q_W = OFF_W - WIN_BITS;

   logic [Q_W-1:0] quarter;
   logic           half_bit;
   logic           qtr_bit;

   assign quarter  = acc_offset[OFF_W-1:WIN_BITS];
   assign half_bit = acc_offset[WIN_BITS-1];
   assign qtr_bit  = acc_offset[WIN_BITS-2];

   always_comb begin
      dec = '{tgt: TGT_NONE, err: 1'b0, narrow: 1'b0, agent: 1'b0};
      if (acc_valid) begin
         case (layout_mode)
            LAY_SMALL: begin
               if (quarter == Q_W'(0))
                  dec.tgt = TGT_WIN_A;
               else if (quarter == Q_W'(1)) begin
                  if (!half_bit)
                     dec.tgt = TGT_EEPROM;
                  else begin
                     dec.tgt    = TGT_BUSCORE;
                     dec.narrow = 1'b1;
                     dec.agent  = qtr_bit;
                  end
               end else
                  dec.err = 1'b1;
            end
            LAY_SPLIT, LAY_DUALWIN: begin
               case (quarter)
                  Q_W'(0): dec.tgt = TGT_WIN_A;
                  Q_W'(1): dec.tgt = (layout_mode == LAY_DUALWIN) ? TGT_WIN_B : TGT_EEPROM;
                  Q_W'(2): dec.tgt = TGT_BUSCORE;
                  default: dec.tgt = TGT_COMMON;
               endcase
            end
            default: dec.err = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/bwx_addr_compose.sv
module bwx_addr_compose
   import bwx_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 14,
   parameter int WIN_BITS = 12,
   localparam int BASE_W  = ADDR_W - WIN_BITS
) (
   input  dec_t                            dec,
   input  logic [OFF_W-1:0]                acc_offset,
   input  logic [NUM_WIN-1:0][BASE_W-1:0]  bases,
   output logic [ADDR_W-1:0]               xlat_addr
);

   logic [WIN_BITS-1:0] local_off;
   logic [WIN_BITS-1:0] core_off;

   assign local_off = acc_offset[WIN_BITS-1:0];
   // The small layout folds the agent slice up to the top quarter of the core.
   assign core_off  = dec.narrow ? {dec.agent, dec.agent, acc_offset[WIN_BITS-3:0]}
                                 : local_off;

   always_comb begin
      case (dec.tgt)
         TGT_WIN_A:              xlat_addr = {bases[0], local_off};
         TGT_WIN_B:              xlat_addr = {bases[1], local_off};
         TGT_EEPROM, TGT_COMMON: xlat_addr = {{BASE_W{1'b0}}, local_off};
         TGT_BUSCORE:            xlat_addr = {{BASE_W{1'b0}}, core_off};
         default:                xlat_addr = '0;
      endcase
   end

endmodule

// File: rtl/bar_window_xlate.sv
module bar_window_xlate
   import bwx_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 14,
   parameter int WIN_BITS = 12,
   localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int BASE_W  = ADDR_W - WIN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [OFF_W-1:0]  acc_offset,
   input  logic [1:0]        layout_mode,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [2:0]        tgt_sel,
   output logic [ADDR_W-1:0] xlat_addr,
   output logic              range_err
);

   if (NUM_WIN != 2) begin : g_bad_nwin
      $error("bar_window_xlate: the layouts use exactly two windows");
   end
   if (OFF_W != WIN_BITS + 2) begin : g_bad_off
      $error("bar_window_xlate: aperture must be four windows wide");
   end
   if (WIN_BITS < 4) begin : g_bad_win
      $error("bar_window_xlate: window too small for the core slices");
   end
   if (ADDR_W <= WIN_BITS) begin : g_bad_addr
      $error("bar_window_xlate: backplane narrower than a window");
   end

   logic [NUM_WIN-1:0][BASE_W-1:0] bases;
   dec_t                           dec;

   bwx_win_regs #(
      .NUM_WIN (NUM_WIN),
      .ADDR_W  (ADDR_W),
      .WIN_BITS(WIN_BITS)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .bases  (bases)
   );

   bwx_region_decode #(
      .OFF_W   (OFF_W),
      .WIN_BITS(WIN_BITS)
   ) u_dec (
      .acc_valid  (acc_valid),
      .layout_mode(layout_mode),
      .acc_offset (acc_offset),
      .dec        (dec)
   );

   bwx_addr_compose #(
      .NUM_WIN (NUM_WIN),
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .WIN_BITS(WIN_BITS)
   ) u_comp (
      .dec       (dec),
      .acc_offset(acc_offset),
      .bases     (bases),
      .xlat_addr (xlat_addr)
   );

   assign tgt_sel   = dec.tgt;
   assign range_err = dec.err;

endmodule

// File: rtl/bwx_checker.sv
module bwx_checker #(
   parameter int NUM_WIN  = 2,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 14,
   parameter int WIN_BITS = 12,
   localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [OFF_W-1:0]  acc_offset,
   input logic [1:0]        layout_mode,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [ADDR_W-1:0] wr_data,
   input logic [2:0]        tgt_sel,
   input logic [ADDR_W-1:0] xlat_addr,
   input logic              range_err
);

   // R5
   small_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && layout_mode == 2'd0 && acc_offset[OFF_W-1])
         |-> (range_err && tgt_sel == 3'd0 && xlat_addr == '0));

   // R8
   bad_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && layout_mode == 2'd3) |-> (range_err && tgt_sel == 3'd0));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (tgt_sel == 3'd0 && !range_err && xlat_addr == '0));

   // R7
   dual_no_eeprom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && layout_mode == 2'd2) |-> (tgt_sel != 3'd3 && !range_err));

   // R9
   win_a_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && wr_idx == IDX_W'(0)) && acc_valid && tgt_sel == 3'd1)
         |-> (xlat_addr[ADDR_W-1:WIN_BITS] == $past(wr_data[ADDR_W-1:WIN_BITS])));

   // R10
   win_a_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && wr_idx == IDX_W'(1)) && $past(acc_valid && tgt_sel == 3'd1)
         && acc_valid && tgt_sel == 3'd1)
         |-> (xlat_addr[ADDR_W-1:WIN_BITS] == $past(xlat_addr[ADDR_W-1:WIN_BITS])));

endmodule

bind bar_window_xlate bwx_checker #(
   .NUM_WIN (NUM_WIN),
   .ADDR_W  (ADDR_W),
   .OFF_W   (OFF_W),
   .WIN_BITS(WIN_BITS)
) u_chk (.*);

// File: tb/tb_bar_window_xlate.sv
`timescale 1ns/1ps
module tb_bar_window_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [13:0] acc_offset = '0;
   logic [1:0]  layout_mode = '0;
   logic        wr_en = 1'b0;
   logic        wr_idx = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  tgt_sel;
   logic [31:0] xlat_addr;
   logic        range_err;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   bit [31:0] m_base [2];

   always #2 clk = ~clk;

   bar_window_xlate dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_offset(acc_offset),
      .layout_mode(layout_mode), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .tgt_sel(tgt_sel), .xlat_addr(xlat_addr), .range_err(range_err)
   );

   function automatic string tag_of(bit v, int mode, int off);
      if (!v) return "R11";
      if (mode == 3) return "R8";
      if (mode == 1) return "R6";
      if (mode == 2) return "R7";
      if (off < 'h1000) return "R2";
      if (off < 'h1800) return "R3";
      if (off < 'h2000) return "R4";
      return "R5";
   endfunction

   task automatic model(input bit v, input int mode, input int off,
                        output int sel, output bit [31:0] addr, output bit err);
      sel = 0; addr = 0; err = 0;
      if (!v) return;
      if (mode == 3) begin err = 1; return; end
      if (off < 'h1000) begin
         sel = 1; addr = (m_base[0] & 32'hFFFF_F000) | off;
      end else if (mode == 0) begin
         if (off < 'h1800)      begin sel = 3; addr = off - 'h1000; end
         else if (off < 'h1C00) begin sel = 4; addr = off - 'h1800; end
         else if (off < 'h2000) begin sel = 4; addr = off - 'h1C00 + 'hC00; end
         else err = 1;
      end else if (off < 'h2000) begin
         if (mode == 2) begin sel = 2; addr = (m_base[1] & 32'hFFFF_F000) | (off - 'h1000); end
         else begin sel = 3; addr = off - 'h1000; end
      end else if (off < 'h3000) begin sel = 4; addr = off - 'h2000; end
      else begin sel = 5; addr = off - 'h3000; end
   endtask

   task automatic step(input bit v, input int mode, input int off, input bit we,
                       input bit idx, input bit [31:0] wd, input string tag);
      int e_sel; bit [31:0] e_addr; bit e_err; string t;
      @(negedge clk);
      acc_valid = v; layout_mode = 2'(mode); acc_offset = 14'(off);
      wr_en = we; wr_idx = idx; wr_data = wd;
      #1;
      model(v, mode, off, e_sel, e_addr, e_err);
      t = (tag == "") ? tag_of(v, mode, off) : tag;
      compared++;
      if (int'(tgt_sel) != e_sel || xlat_addr != e_addr || range_err != e_err) begin
         mismatched++;
         $display("FAIL %s mode=%0d off=%h: got sel=%0d addr=%h err=%0b, expected sel=%0d addr=%h err=%0b",
                  t, mode, off, tgt_sel, xlat_addr, range_err, e_sel, e_addr, e_err);
      end
      if (we && rst_n) m_base[idx] = wd;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int offs [12] = '{'h0000, 'h0FFF, 'h1000, 'h17FF, 'h1800, 'h1BFF,
                        'h1C00, 'h1FFF, 'h2000, 'h2FFF, 'h3000, 'h3FFF};
      m_base[0] = 0; m_base[1] = 0;
      // R1: reset state, window bases zero
      step(1, 0, 'h0123, 0, 0, 0, "R1");
      step(1, 2, 'h1ABC, 0, 0, 0, "R1");
      @(negedge clk); rst_n = 1'b1;
      step(1, 0, 'h0456, 0, 0, 0, "R1");
      // R9: the write-cycle access sees the old base, the next one the new base
      step(1, 0, 'h0010, 1, 0, 32'hABCD_E777, "R9");
      step(1, 0, 'h0010, 0, 0, 0, "R9");
      // R10: a write to base B leaves base A alone, and the reverse
      step(1, 1, 'h0FF0, 1, 1, 32'h1234_5FFF, "R10");
      step(1, 1, 'h0FF0, 0, 0, 0, "R10");
      step(1, 2, 'h1004, 1, 0, 32'h8000_0000, "R10");
      step(1, 2, 'h1004, 0, 0, 0, "R10");
      step(1, 2, 'h0004, 0, 0, 0, "R10");
      // R2 R3 R4 R5 R6 R7 R8: every region boundary in every layout
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 12; i++)
            step(1, m, offs[i], 0, 0, 0, "");
      // R11: idle cycles with a busy-looking offset
      step(0, 0, 'h0ABC, 0, 0, 0, "R11");
      step(0, 3, 'h3FFF, 0, 0, 0, "R11");
      // random mix of accesses and writes on adjacent cycles
      for (int n = 0; n < 4000; n++)
         step(($urandom % 8) != 0, $urandom % 4, $urandom % 'h4000,
              ($urandom % 4) == 0, 1'($urandom % 2), $urandom, "");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule